// File: doc/BRIEF.md
# Dual Bidirectional Parallel Port

This block gives a processor two byte-wide general-purpose pin groups, port A and port B, reached through a small synchronous register bus. Each port holds an output byte and a direction byte. A pin whose direction bit is 1 is driven with its output bit. A pin whose direction bit is 0 is left undriven, so an external source sets its level.

The block drives no pads itself. For every pin it presents an output value and an active-high output enable, which the pad ring combines into a tri-state buffer. Pin levels enter through a two-stage synchronizer. A read of a port's data address returns a blend, bit by bit: where the direction bit is 1, the bit comes from the output byte; where it is 0, it comes from the synchronized pin level.

Writes to a data address always update the output byte, even for pins that are currently inputs. This lets software load a value before it turns a pin into an output, so the pin shows no glitch when it starts to drive.

Top module: `dual_pio`

## Requirements
- R1: While reset is low and right after reset, both output bytes and both direction bytes are 0x00, so every output enable is low and every output value is low.
- R2: The register map is fixed: 0x00 is the port A data byte, 0x01 the port B data byte, 0x04 the port A direction byte and 0x05 the port B direction byte. A write takes effect on the rising clock edge where `bus_sel` and `bus_wr` are both high.
- R3: A write to a data address stores the byte in that port's output byte whatever its direction. The port's output value pins show the stored byte from the edge of the write onward.
- R4: Each output enable bit equals the matching direction bit. Setting a direction bit to 1 drives the stored output bit on the next cycle, even when that bit was written while the pin was an input.
- R5: A read of a data address returns, for bits with direction 1, the output byte bit, and for bits with direction 0, the synchronized pin level.
- R6: A read of a direction address returns the stored direction byte.
- R7: A read of any other address returns 0x00, and a write to any other address changes no register. `bus_rdata` is 0x00 whenever `bus_sel` is low.
- R8: A change on an input pin shows in read data after the second rising clock edge that follows it, and not after the first.
- R9: A write to one port's registers leaves the other port's output byte and direction byte unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Selects the block for a bus access |
| bus_wr | input | 1 | 1 means write, 0 means read |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| pa_in | input | 8 | Port A pin levels from the pads |
| pa_out | output | 8 | Port A output values |
| pa_oe | output | 8 | Port A output enables, active high |
| pb_in | input | 8 | Port B pin levels from the pads |
| pb_out | output | 8 | Port B output values |
| pb_oe | output | 8 | Port B output enables, active high |

## Verification
The assertions check on every cycle that a write to a data or direction address shows on the matching output or enable pins on the next cycle. They also check that the pins hold their value when no such write occurs, that unmapped and unselected reads return zero, and that a data read with every bit set to output returns the latch. The per-bit blend of latch and pin on a data read, the two-edge delay from a pin change to read data, and a latch value written while a pin is an input and later driven depend on sequences of stimulus. Only the bench's directed scenarios can show those.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int PIO_ADDR_W = 8;
  typedef logic [PIO_ADDR_W-1:0] pio_addr_t;

  // Base addresses; port p sits at base + p.
  localparam pio_addr_t PIO_DATA_BASE = 8'h00;
  localparam pio_addr_t PIO_DIR_BASE  = 8'h04;

  typedef enum logic [1:0] {
    PIO_HIT_NONE = 2'd0,
    PIO_HIT_DATA = 2'd1,
    PIO_HIT_DIR  = 2'd2
  } pio_hit_e;

  function automatic pio_addr_t pio_data_addr(input int port);
    return pio_addr_t'(PIO_DATA_BASE + pio_addr_t'(port));
  endfunction

  function automatic pio_addr_t pio_dir_addr(input int port);
    return pio_addr_t'(PIO_DIR_BASE + pio_addr_t'(port));
  endfunction
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/pio_decode.sv
module pio_decode
  import pio_pkg::*;
#(
  parameter int NPORT = 2
) (
  input  pio_addr_t        addr,
  output logic [NPORT-1:0] hit_data,
  output logic [NPORT-1:0] hit_dir,
  output logic             mapped
);
  for (genvar p = 0; p < NPORT; p++) begin : g_dec
    assign hit_data[p] = (addr == pio_data_addr(p));
    assign hit_dir[p]  = (addr == pio_dir_addr(p));
  end

  assign mapped = (|hit_data) | (|hit_dir);
endmodule

// File: rtl/pio_port.sv
module pio_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_data_en,
  input  logic         wr_dir_en,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] data_view,
  output logic [W-1:0] dir_view
);
  logic [W-1:0] latch_q;
  logic [W-1:0] dir_q;
  logic [W-1:0] pin_s;

  // Per bit: a driven pin reads back its latch, an undriven one its level.
  function automatic logic [W-1:0] blend(input logic [W-1:0] latch,
                                         input logic [W-1:0] dir,
                                         input logic [W-1:0] lvl);
    return (latch & dir) | (lvl & ~dir);
  endfunction

  pio_sync #(.W(W)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (pin_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
    end else begin
      if (wr_data_en) latch_q <= wdata;
      if (wr_dir_en)  dir_q   <= wdata;
    end
  end

  assign pin_out   = latch_q;
  assign pin_oe    = dir_q;
  assign data_view = blend(latch_q, dir_q, pin_s);
  assign dir_view  = dir_q;
endmodule

// File: rtl/dual_pio.sv
module dual_pio
  import pio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [PIO_ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]          bus_wdata,
  output logic [W-1:0]          bus_rdata,
  input  logic [W-1:0]          pa_in,
  output logic [W-1:0]          pa_out,
  output logic [W-1:0]          pa_oe,
  input  logic [W-1:0]          pb_in,
  output logic [W-1:0]          pb_out,
  output logic [W-1:0]          pb_oe
);
  localparam int NPORT = 2;

  logic [NPORT-1:0] hit_data;
  logic [NPORT-1:0] hit_dir;
  logic             addr_mapped;
  logic             wr_fire;
  pio_hit_e         hit_kind;

  logic [W-1:0] pin_in_a   [NPORT];
  logic [W-1:0] pin_out_a  [NPORT];
  logic [W-1:0] pin_oe_a   [NPORT];
  logic [W-1:0] data_view_a[NPORT];
  logic [W-1:0] dir_view_a [NPORT];

  assign wr_fire = bus_sel & bus_wr;

  pio_decode #(.NPORT(NPORT)) u_dec (
    .addr     (bus_addr),
    .hit_data (hit_data),
    .hit_dir  (hit_dir),
    .mapped   (addr_mapped)
  );

  assign hit_kind = (|hit_data) ? PIO_HIT_DATA :
                    (|hit_dir)  ? PIO_HIT_DIR  : PIO_HIT_NONE;

  assign pin_in_a[0] = pa_in;
  assign pin_in_a[1] = pb_in;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    pio_port #(.W(W)) u_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_data_en (wr_fire & hit_data[p]),
      .wr_dir_en  (wr_fire & hit_dir[p]),
      .wdata      (bus_wdata),
      .pin_in     (pin_in_a[p]),
      .pin_out    (pin_out_a[p]),
      .pin_oe     (pin_oe_a[p]),
      .data_view  (data_view_a[p]),
      .dir_view   (dir_view_a[p])
    );
  end

  assign pa_out = pin_out_a[0];
  assign pa_oe  = pin_oe_a[0];
  assign pb_out = pin_out_a[1];
  assign pb_oe  = pin_oe_a[1];

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      for (int p = 0; p < NPORT; p++) begin
        if (hit_kind == PIO_HIT_DATA && hit_data[p]) bus_rdata = data_view_a[p];
        if (hit_kind == PIO_HIT_DIR  && hit_dir[p])  bus_rdata = dir_view_a[p];
      end
    end
  end
endmodule

// File: rtl/pio_checker.sv
module pio_checker
  import pio_pkg::*;
#(
  parameter int W = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_sel,
  input logic                  bus_wr,
  input logic [PIO_ADDR_W-1:0] bus_addr,
  input logic [W-1:0]          bus_wdata,
  input logic [W-1:0]          bus_rdata,
  input logic [W-1:0]          pa_out,
  input logic [W-1:0]          pa_oe,
  input logic [W-1:0]          pb_out,
  input logic [W-1:0]          pb_oe,
  input logic                  wr_fire,
  input logic                  addr_mapped
);
  logic wr_pa_d, wr_pb_d, wr_pa_dir, wr_pb_dir;
  assign wr_pa_d   = bus_sel && bus_wr && bus_addr == 8'h00;
  assign wr_pb_d   = bus_sel && bus_wr && bus_addr == 8'h01;
  assign wr_pa_dir = bus_sel && bus_wr && bus_addr == 8'h04;
  assign wr_pb_dir = bus_sel && bus_wr && bus_addr == 8'h05;

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |-> (pa_oe == '0 && pb_oe == '0 && pa_out == '0 && pb_out == '0));

  assert_latch_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pa_d |=> pa_out == $past(bus_wdata));

  assert_latch_write_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pb_d |=> pb_out == $past(bus_wdata));

  assert_oe_follows_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pa_dir |=> pa_oe == $past(bus_wdata));

  assert_oe_b_follows_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pb_dir |=> pb_oe == $past(bus_wdata));

  assert_hold_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_pa_d || wr_pa_dir) |=> ($stable(pa_out) && $stable(pa_oe)));

  assert_hold_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_pb_d || wr_pb_dir) |=> ($stable(pb_out) && $stable(pb_oe)));

  assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_sel || !addr_mapped) |-> bus_rdata == '0);

  assert_driven_reads_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_addr == 8'h00 && pa_oe == '1) |-> bus_rdata == pa_out);

  assert_dir_readback_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !wr_fire && bus_addr == 8'h05) |-> bus_rdata == pb_oe);
endmodule

bind dual_pio pio_checker #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_sel     (bus_sel),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .pa_out      (pa_out),
  .pa_oe       (pa_oe),
  .pb_out      (pb_out),
  .pb_oe       (pb_oe),
  .wr_fire     (wr_fire),
  .addr_mapped (addr_mapped)
);

// File: tb/sim_dual_pio.sv
`timescale 1ns/1ps
module sim_dual_pio;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] pa_in = 8'h00;
  logic [7:0] pa_out, pa_oe;
  logic [7:0] pb_in = 8'h00;
  logic [7:0] pb_out, pb_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dual_pio u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe)
  );

  task automatic check(input string req, input string what,
                       input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, got, exp);
    end
  endtask

  // Bench's own view of a data read: walk bit by bit.
  function automatic logic [7:0] expect_read(input logic [7:0] lat,
                                             input logic [7:0] dir,
                                             input logic [7:0] pins);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = dir[i] ? lat[i] : pins[i];
    return r;
  endfunction

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R1", "pa_oe", pa_oe, 8'h00);
    check("R1", "pb_oe", pb_oe, 8'h00);
    check("R1", "pa_out", pa_out, 8'h00);
    check("R1", "pb_out", pb_out, 8'h00);
    bus_read(8'h04, v); check("R1", "dir A", v, 8'h00);
  endtask

  task automatic t_latch_while_input;
    logic [7:0] v;
    pa_in = 8'h3C;
    bus_write(8'h00, 8'hA5);
    check("R3", "pa_out after write", pa_out, 8'hA5);
    check("R4", "pa_oe still off", pa_oe, 8'h00);
    bus_read(8'h00, v); check("R5", "all-input read", v, 8'h3C);
    bus_write(8'h04, 8'hFF);
    check("R4", "pa_oe enabled", pa_oe, 8'hFF);
    check("R4", "stored latch now driven", pa_out, 8'hA5);
    bus_read(8'h00, v); check("R5", "all-output read", v, 8'hA5);
  endtask

  task automatic t_mixed;
    logic [7:0] v;
    bus_write(8'h04, 8'hF0);
    bus_write(8'h00, 8'h96);
    pa_in = 8'h5A;
    repeat (3) @(negedge clk);
    bus_read(8'h00, v); check("R5", "mixed read", v, expect_read(8'h96, 8'hF0, 8'h5A));
    bus_read(8'h04, v); check("R6", "dir A readback", v, 8'hF0);
  endtask

  task automatic t_port_b_and_isolation;
    logic [7:0] v;
    bus_write(8'h05, 8'h0F);
    bus_write(8'h01, 8'hC3);
    check("R2", "pb_out", pb_out, 8'hC3);
    check("R2", "pb_oe", pb_oe, 8'h0F);
    check("R9", "pa_out kept", pa_out, 8'h96);
    check("R9", "pa_oe kept", pa_oe, 8'hF0);
    pb_in = 8'h81;
    repeat (3) @(negedge clk);
    bus_read(8'h01, v); check("R5", "port B read", v, expect_read(8'hC3, 8'h0F, 8'h81));
    bus_read(8'h05, v); check("R6", "dir B readback", v, 8'h0F);
  endtask

  task automatic t_unmapped;
    logic [7:0] v;
    bus_write(8'h02, 8'hEE);
    bus_write(8'h07, 8'hEE);
    check("R7", "pa_out after stray", pa_out, 8'h96);
    check("R7", "pb_oe after stray", pb_oe, 8'h0F);
    bus_read(8'h02, v); check("R7", "read 0x02", v, 8'h00);
    bus_read(8'h06, v); check("R7", "read 0x06", v, 8'h00);
    @(negedge clk); bus_sel = 1'b0; bus_addr = 8'h04;
    #1 check("R7", "sel low", bus_rdata, 8'h00);
  endtask

  task automatic t_sync;
    bus_write(8'h04, 8'h00);
    pa_in = 8'h11;
    repeat (3) @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h00;
    pa_in = 8'hE7;
    @(negedge clk);
    #1 check("R8", "after one edge", bus_rdata, 8'h11);
    @(negedge clk);
    #1 check("R8", "after two edges", bus_rdata, 8'hE7);
    bus_sel = 1'b0;
  endtask

  initial begin
    #1 check("R1", "oe in reset", pa_oe | pb_oe, 8'h00);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_latch_while_input();
    t_mixed();
    t_port_b_and_isolation();
    t_unmapped();
    t_sync();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule